// File: doc/BRIEF.md
# Watchdog Timer with Protected Disable

This block supervises software through a timeout counter. While it is running, the counter advances on each cycle where a slow-clock enable input is high. If software does not restart it in time with the kick input, the block raises a reset pulse for one cycle. The counter then starts again from zero. A 3-bit select sets the timeout length, from 2^BASE_LOG2 ticks up to 2^(BASE_LOG2+7) ticks. With the default BASE_LOG2 of 14, that range is 16,384 to 2,097,152 ticks.

Software reaches the block through a write strobe and a data word. A control word can always be read back. Any write can turn the watchdog on. Turning it off is protected. An unlock write sets the run bit and the unlock bit together. This opens a window that lasts WIN_CYCLES clock cycles (4 by default). A write that clears the run bit disables the watchdog only while that window is open. The unlock bit clears itself when the window closes.

Top module: `wdg_guard`

## Requirements
- R1: After reset the run bit, the unlock bit and the select all read 0, and the reset pulse output is low.
- R2: The control word is laid out as bit 0 = run, bit 1 = unlock and bits 4:2 = timeout select. The remaining upper bits read 0 and ignore writes. Every write loads the select field.
- R3: A write with both bit 0 and bit 1 set to one sets the run bit and opens the window. The unlock bit then reads 1. A write with bit 1 set but bit 0 clear does not open the window.
- R4: If the unlock write lands on clock edge t, a write with bit 0 clear on any of edges t+1 to t+4 clears the run bit.
- R5: Four cycles after the unlock write, the unlock bit returns to 0 without any further write. A write with bit 0 clear on edge t+5 or later leaves the run bit at 1.
- R6: While no window is open, a write with bit 0 clear leaves the run bit at 1.
- R7: While running, the first reset pulse follows the 2^(BASE_LOG2+sel)-th counted tick after enabling.
- R8: The reset pulse lasts one cycle, and the counter restarts. The next pulse follows the same number of further ticks.
- R9: The counter advances only on cycles where the tick input is high.
- R10: A kick restarts the count from zero, so the next pulse needs a full period of ticks after the kick.
- R11: While the watchdog is disabled, no reset pulse occurs, whatever the tick input and the select do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | DATA_W | Control word to write |
| rd_data_o | output | DATA_W | Current control word |
| kick_i | input | 1 | Restarts the timeout count |
| tick_i | input | 1 | Watchdog-clock enable; the counter advances when high |
| wdg_rst_o | output | 1 | One-cycle reset pulse on timeout |

## Verification
The bench uses a small BASE_LOG2 and sweeps all eight select values. It first keeps the tick input high, which checks that each select value doubles the period. It then feeds ticks on one cycle in three, which separates counting ticks from counting clock cycles. The disable sequence is tried with the clearing write placed 1 to 6 cycles after the unlock write. This pins the exact last cycle of the window and shows that the unlock bit expires by itself. Clearing writes with no unlock, unlock writes with the run bit clear, and both single and repeated kicks show that only a proper sequence disables the block and that a kick fully restarts the period.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int SEL_W = 3;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic             unlock;
    logic             run;
  } wdg_ctrl_t;

  localparam int CTRL_W = $bits(wdg_ctrl_t);

  // Timeout in ticks: the base length doubled once per select step.
  function automatic logic [31:0] wdg_limit(input int base_log2, input logic [SEL_W-1:0] sel);
    return 32'd1 << (base_log2 + int'(sel));
  endfunction
endpackage

// File: rtl/wdg_ctrl.sv
module wdg_ctrl
  import wdg_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int WIN_CYCLES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              run_o,
  output logic              unlock_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic              unlock_evt_o,
  output logic              disable_evt_o
);
  localparam int WIN_W = $clog2(WIN_CYCLES + 1);

  wdg_ctrl_t         wr_word;
  logic [WIN_W-1:0]  win_q;
  logic              run_q;
  logic [SEL_W-1:0]  sel_q;
  logic              window_open;

  assign wr_word       = wdg_ctrl_t'(wr_data_i[CTRL_W-1:0]);
  assign window_open   = (win_q != '0);
  assign unlock_evt_o  = wr_en_i & wr_word.run & wr_word.unlock;
  assign disable_evt_o = wr_en_i & ~unlock_evt_o & window_open & ~wr_word.run & run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      sel_q <= '0;
      win_q <= '0;
    end else begin
      if (wr_en_i) sel_q <= wr_word.sel;
      if (unlock_evt_o) begin
        run_q <= 1'b1;
        win_q <= WIN_W'(WIN_CYCLES);
      end else if (wr_en_i) begin
        run_q <= window_open ? wr_word.run : (run_q | wr_word.run);
        win_q <= '0;
      end else if (window_open) begin
        win_q <= win_q - 1'b1;
      end
    end
  end

  assign run_o    = run_q;
  assign unlock_o = window_open;
  assign sel_o    = sel_q;
endmodule

// File: rtl/wdg_timeout.sv
module wdg_timeout
  import wdg_pkg::*;
#(
  parameter int BASE_LOG2 = 14,
  parameter int CNT_W     = BASE_LOG2 + (1 << SEL_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             kick_i,
  input  logic             tick_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_evt_o,
  output logic             pulse_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [31:0]      limit;
  logic [31:0]      cnt_ext;

  assign limit      = wdg_limit(BASE_LOG2, sel_i);
  assign cnt_ext    = 32'(cnt_q);
  assign wrap_evt_o = run_i & tick_i & ~kick_i & (cnt_ext >= limit - 32'd1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= wrap_evt_o;
      if (!run_i || kick_i || wrap_evt_o) cnt_q <= '0;
      else if (tick_i)                    cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/wdg_guard.sv
module wdg_guard
  import wdg_pkg::*;
#(
  parameter int BASE_LOG2  = 14,
  parameter int DATA_W     = 8,
  parameter int WIN_CYCLES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              kick_i,
  input  logic              tick_i,
  output logic              wdg_rst_o
);
  localparam int CNT_W = BASE_LOG2 + (1 << SEL_W);

  logic             run_w;
  logic             unlock_w;
  logic [SEL_W-1:0] sel_w;
  logic             unlock_evt_w;
  logic             disable_evt_w;
  logic [CNT_W-1:0] cnt_w;
  logic             wrap_evt_w;
  wdg_ctrl_t        rd_word;

  wdg_ctrl #(.DATA_W(DATA_W), .WIN_CYCLES(WIN_CYCLES)) i_ctrl (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i,
    .run_o(run_w), .unlock_o(unlock_w), .sel_o(sel_w),
    .unlock_evt_o(unlock_evt_w), .disable_evt_o(disable_evt_w)
  );

  wdg_timeout #(.BASE_LOG2(BASE_LOG2), .CNT_W(CNT_W)) i_timeout (
    .clk_i, .rst_ni, .run_i(run_w), .kick_i, .tick_i, .sel_i(sel_w),
    .cnt_o(cnt_w), .wrap_evt_o(wrap_evt_w), .pulse_o(wdg_rst_o)
  );

  assign rd_word   = '{sel: sel_w, unlock: unlock_w, run: run_w};
  assign rd_data_o = DATA_W'(rd_word);
endmodule

// File: rtl/wdg_guard_chk.sv
module wdg_guard_chk #(
  parameter int WIN_CYCLES = 4,
  parameter int CNT_W      = 22
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_w,
  input logic             unlock_w,
  input logic             kick_i,
  input logic             tick_i,
  input logic [CNT_W-1:0] cnt_w,
  input logic             wdg_rst_o
);
  localparam int OW = $clog2(WIN_CYCLES + 2) + 1;
  logic [OW-1:0] open_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       open_run <= '0;
    else if (unlock_w) open_run <= open_run + 1'b1;
    else               open_run <= '0;
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdg_rst_o |=> !wdg_rst_o); // R8
  AST_OFF_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(run_w) |-> !wdg_rst_o); // R11
  AST_CLEAR_NEEDS_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(run_w) |-> $past(unlock_w)); // R6
  AST_WINDOW_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    open_run <= OW'(WIN_CYCLES)); // R5
  AST_KICK_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_i |=> !wdg_rst_o); // R10
  AST_TICK_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_w && !tick_i && !kick_i) |=> $stable(cnt_w)); // R9
endmodule

bind wdg_guard wdg_guard_chk #(.WIN_CYCLES(WIN_CYCLES), .CNT_W(CNT_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .run_w(run_w), .unlock_w(unlock_w),
  .kick_i(kick_i), .tick_i(tick_i), .cnt_w(cnt_w), .wdg_rst_o(wdg_rst_o)
);

// File: tb/test_wdg_guard.sv
`timescale 1ns/1ps
module test_wdg_guard;
  localparam int BASE = 2;
  localparam int DW   = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [DW-1:0] wr_data_i = '0;
  logic [DW-1:0] rd_data_o;
  logic          kick_i = 1'b0;
  logic          tick_i = 1'b1;
  logic          wdg_rst_o;

  int checks = 0;
  int errors = 0;

  wdg_guard #(.BASE_LOG2(BASE), .DATA_W(DW), .WIN_CYCLES(4)) i_wdg_guard (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i, .rd_data_o, .kick_i, .tick_i, .wdg_rst_o
  );

  always #2.5 clk_i = ~clk_i;

  function automatic logic [DW-1:0] mk(input bit run, input bit unl, input int sel);
    return DW'({sel[2:0], unl, run});
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Called at a negedge; the write is taken on the next posedge.
  task automatic wr(input logic [DW-1:0] d);
    wr_en_i = 1'b1; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic go_off();
    wr(mk(1, 1, 0));
    wr(mk(0, 0, 0));
  endtask

  // Counts ticks; records the tick count seen at the first two pulses.
  task automatic measure(input int lim, input int pat, output int t1, output int t2, output int np);
    int tc;
    tc = 0; t1 = -1; t2 = -1; np = 0;
    for (int n = 0; n < lim * 6 + 8; n++) begin
      tick_i = (pat == 0) ? 1'b1 : (n % 3 == 0);
      @(negedge clk_i);
      if (tick_i) tc++;
      if (wdg_rst_o) begin
        np++;
        if (t1 < 0) t1 = tc; else if (t2 < 0) t2 = tc;
      end
      if (t2 >= 0) break;
    end
    tick_i = 1'b1;
  endtask

  task automatic count_pulses(input int n, output int np);
    np = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      if (wdg_rst_o) np++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int t1, t2, np, lim;
    idle(3);
    // R1: reset state
    chk("R1 rd_data", int'(rd_data_o), 0);
    chk("R1 pulse", int'(wdg_rst_o), 0);
    rst_ni = 1'b1;
    idle(2);
    chk("R1 rd_data after release", int'(rd_data_o), 0);

    // R2: layout, upper bits ignored, select written while off
    wr(8'hE0 | mk(0, 0, 5));
    chk("R2 layout readback", int'(rd_data_o), 8'h14);
    // R11: off, ticking, no pulse
    count_pulses(300, np);
    chk("R11 no pulse while off", np, 0);

    // R7 R8: sweep all select values with continuous ticks
    for (int s = 0; s < 8; s++) begin
      lim = (1 << (BASE + s));
      wr(mk(1, 0, s));
      chk("R2 enabled readback", int'(rd_data_o), int'(mk(1, 0, s)));
      measure(lim, 0, t1, t2, np);
      chk($sformatf("R7 first pulse sel=%0d", s), t1, lim);
      chk($sformatf("R8 second pulse sel=%0d", s), t2, 2 * lim);
      chk($sformatf("R8 pulse count sel=%0d", s), np, 2);
      go_off();
      chk("R4 disabled after sweep", int'(rd_data_o[0]), 0);
    end

    // R9: ticks on one cycle in three
    wr(mk(1, 0, 1));
    measure(8, 1, t1, t2, np);
    chk("R9 first pulse in ticks", t1, 8);
    chk("R9 second pulse in ticks", t2, 16);
    go_off();

    // R10: single kick restarts the full period
    wr(mk(1, 0, 0));
    idle(2);
    kick_i = 1'b1; @(negedge clk_i); kick_i = 1'b0;
    measure(4, 0, t1, t2, np);
    chk("R10 pulse after kick", t1, 4);
    // R10: kicks every third cycle prevent any pulse
    np = 0;
    for (int i = 0; i < 30; i++) begin
      kick_i = 1'b1; @(negedge clk_i); kick_i = 1'b0;
      idle(2);
      if (wdg_rst_o) np++;
    end
    chk("R10 repeated kicks no pulse", np, 0);

    // R3 R6: unlock attempt with run bit clear, then plain clear
    wr(mk(0, 1, 0));
    chk("R3 no window without run bit", int'(rd_data_o[1]), 0);
    chk("R6 run kept after bad unlock", int'(rd_data_o[0]), 1);
    wr(mk(0, 0, 0));
    chk("R6 run kept after plain clear", int'(rd_data_o[0]), 1);

    // R3 R4 R5: clear write placed k cycles after the unlock write
    for (int k = 1; k <= 6; k++) begin
      if (rd_data_o[0] == 1'b0) wr(mk(1, 0, 0));
      wr(mk(1, 1, 0));
      chk("R3 unlock bit set", int'(rd_data_o[1]), 1);
      idle(k - 1);
      chk($sformatf("R5 unlock bit before clear k=%0d", k), int'(rd_data_o[1]), (k <= 4) ? 1 : 0);
      wr(mk(0, 0, 0));
      if (k <= 4) chk($sformatf("R4 disabled k=%0d", k), int'(rd_data_o[0]), 0);
      else        chk($sformatf("R5 still running k=%0d", k), int'(rd_data_o[0]), 1);
    end

    // R11: disabled mid-count, select changes, no pulse
    go_off();
    wr(mk(0, 0, 0));
    count_pulses(20, np);
    wr(mk(0, 0, 7));
    count_pulses(40, t1);
    chk("R11 no pulse after disable", np + t1, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule